// File: doc/BRIEF.md
# Tree Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock. Each bit position first forms a propagate and a generate term from its two operand bits. A balanced binary tree of merge nodes then combines neighbouring groups into larger groups, working up to a root that covers the whole word.

Carries travel back down the same tree. The root receives the carry-in. Each node passes its own carry-in to its lower half unchanged. Its upper half receives the lower half's generate, ORed with the node's carry-in ANDed with the lower half's propagate. Every leaf XORs its propagate with the carry it receives to form its sum bit.

The word-level propagate and generate are also output, so the adder can act as one group inside a wider lookahead structure. The operand width is a power-of-two parameter, 8 by default. Carry depth grows with the base-2 logarithm of the width rather than linearly.

Top module: `cla_tree_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i` + `c_i`) modulo 2^WIDTH, with the operands taken as unsigned.
- R2: `c_o` equals bit WIDTH of the full-precision sum `a_i` + `b_i` + `c_i`.
- R3: `grp_p_o` is 1 exactly when every bit position has one operand bit set and the other clear, that is when (`a_i` XOR `b_i`) is all ones.
- R4: `grp_g_o` is 1 exactly when `a_i` + `b_i` without the carry-in reaches 2^WIDTH or more.
- R5: `c_o` equals `grp_g_o` OR (`grp_p_o` AND `c_i`) for every input.
- R6: When `grp_p_o` is 1, the carry-in passes straight through. `c_o` equals `c_i`, and `sum_o` is all ones when `c_i` is 0 and all zeros when `c_i` is 1.
- R7: The parameter WIDTH accepts any power of two from 2 upward. A 16-bit instance meets R1 to R5 in the same way as the default 8-bit one.
- R8: The block holds no state. Its outputs depend only on the present inputs and settle in the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| c_o | output | 1 | Carry out of the top bit |
| grp_p_o | output | 1 | Propagate of the whole word |
| grp_g_o | output | 1 | Generate of the whole word |

## Verification
Every result is due zero cycles after its stimulus, because no register lies on any path. The bench changes the inputs only just after a falling clock edge. It samples all four outputs a few nanoseconds later, in the same half-period and before the next rising edge, so no check depends on a clock.

The 8-bit instance is swept over every operand pair with both carry-in values. Seeded random vectors and directed corners also exercise a 16-bit instance. Both cases are compared with a plain integer addition done in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;

  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  function automatic bit is_pow2(input int unsigned w);
    return (w >= 2) && ((w & (w - 1)) == 0);
  endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell
  import cla_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output pg_t  pg_o,
  output logic s_o
);

  // propagate doubles as the half-sum
  assign pg_o.p = a_i ^ b_i;
  assign pg_o.g = a_i & b_i;
  assign s_o    = pg_o.p ^ c_i;

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      p_leaf_sum_r1: assert (s_o == (a_i ^ b_i ^ c_i))
        else $error("leaf sum mismatch");
    end
  end

endmodule

// File: rtl/cla_pg_merge.sv
module cla_pg_merge
  import cla_pkg::*;
(
  input  pg_t  lo_i,
  input  pg_t  hi_i,
  input  logic c_i,
  output pg_t  grp_o,
  output logic c_hi_o
);

  assign grp_o.p = lo_i.p & hi_i.p;
  assign grp_o.g = hi_i.g | (hi_i.p & lo_i.g);
  assign c_hi_o  = lo_i.g | (lo_i.p & c_i);

  always_comb begin
    if (!$isunknown({lo_i, hi_i, c_i})) begin
      // a group cannot both create and pass a carry
      p_node_excl_r4: assert (!(grp_o.p && grp_o.g))
        else $error("node generates and propagates at once");
      p_node_kill_r5: assert ((lo_i.p || lo_i.g) || !c_hi_o)
        else $error("killed lower half still carries");
    end
  end

endmodule

// File: rtl/cla_tree_adder.sv
module cla_tree_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             grp_p_o,
  output logic             grp_g_o
);

  localparam int unsigned NODES = 2 * WIDTH;

  // heap layout: root at 1, children of k at 2k (low) and 2k+1 (high),
  // leaf i at WIDTH+i
  logic [NODES-1:1] node_p;
  logic [NODES-1:1] node_g;
  logic [NODES-1:1] node_c;

  initial begin
    if (!is_pow2(WIDTH)) $error("WIDTH must be a power of two >= 2");
  end

  assign node_c[1] = c_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_leaf
    cla_bit_cell u_cell (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (node_c[WIDTH+i]),
      .pg_o ({node_p[WIDTH+i], node_g[WIDTH+i]}),
      .s_o  (sum_o[i])
    );
  end

  for (genvar k = 1; k < WIDTH; k++) begin : g_node
    assign node_c[2*k] = node_c[k];
    cla_pg_merge u_merge (
      .lo_i   ({node_p[2*k],   node_g[2*k]}),
      .hi_i   ({node_p[2*k+1], node_g[2*k+1]}),
      .c_i    (node_c[k]),
      .grp_o  ({node_p[k], node_g[k]}),
      .c_hi_o (node_c[2*k+1])
    );
  end

  assign grp_p_o = node_p[1];
  assign grp_g_o = node_g[1];
  assign c_o     = node_g[1] | (node_p[1] & c_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      p_sum_r1: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(c_i)))
        else $error("sum or carry-out differs from addition");
      p_grp_p_r3: assert (grp_p_o == &(a_i ^ b_i))
        else $error("word propagate wrong");
      p_grp_g_r4: assert (grp_g_o == (({1'b0, a_i} + {1'b0, b_i}) >> WIDTH))
        else $error("word generate wrong");
      p_pass_r6: assert (!grp_p_o || (c_o == c_i && sum_o == {WIDTH{~c_i}}))
        else $error("propagating word does not pass carry");
    end
  end

endmodule

// File: tb/cla_tree_adder_test.sv
`timescale 1ns/1ps
module cla_tree_adder_test;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0]  a8, b8, s8;
  logic        ci8, co8, gp8, gg8;
  logic [15:0] a16, b16, s16;
  logic        ci16, co16, gp16, gg16;

  cla_tree_adder #(.WIDTH(8)) uut (
    .a_i(a8), .b_i(b8), .c_i(ci8),
    .sum_o(s8), .c_o(co8), .grp_p_o(gp8), .grp_g_o(gg8)
  );

  cla_tree_adder #(.WIDTH(16)) uut16 (
    .a_i(a16), .b_i(b16), .c_i(ci16),
    .sum_o(s16), .c_o(co16), .grp_p_o(gp16), .grp_g_o(gg16)
  );

  function automatic logic [16:0] exp_sum(input logic [15:0] a, input logic [15:0] b,
                                          input logic c, input int w);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b} + 17'(c);
    if (w == 8) t = {8'd0, t[8:0]};
    return t;
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // combinational: drive after falling edge, sample 3 ns later
  task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic c);
    logic [16:0] e;
    @(negedge clk);
    a8 = a; b8 = b; ci8 = c;
    #3;
    e = exp_sum({8'd0, a}, {8'd0, b}, c, 8);
    chk("R1 sum8", 17'(s8), 17'(e[7:0]));
    chk("R2 cout8", 17'(co8), 17'(e[8]));
    chk("R3 gp8", 17'(gp8), 17'(&(a ^ b)));
    chk("R4 gg8", 17'(gg8), 17'(({1'b0, a} + {1'b0, b}) >> 8));
    chk("R5 cout8 vs pg", 17'(co8), 17'(gg8 | (gp8 & c)));
    if (&(a ^ b)) begin
      chk("R6 pass cout", 17'(co8), 17'(c));
      chk("R6 pass sum", 17'(s8), c ? 17'h0 : 17'hff);
    end
  endtask

  task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] e;
    @(negedge clk);
    a16 = a; b16 = b; ci16 = c;
    #3;
    e = exp_sum(a, b, c, 16);
    chk("R7 sum16", 17'(s16), 17'(e[15:0]));
    chk("R7 cout16", 17'(co16), 17'(e[16]));
    chk("R7 gp16", 17'(gp16), 17'(&(a ^ b)));
    chk("R7 gg16", 17'(gg16), 17'(({1'b0, a} + {1'b0, b}) >> 16));
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd20021011;
    void'($urandom(seed));
    a8 = '0; b8 = '0; ci8 = 1'b0;
    a16 = '0; b16 = '0; ci16 = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #3;
    // R8: idle state, no clock edge involved
    chk("R8 zero sum", 17'(s8), 17'h0);
    chk("R8 zero flags", 17'({co8, gp8, gg8}), 17'h0);
    // R8: response within the same half-period
    @(negedge clk);
    a8 = 8'hff; b8 = 8'h01; ci8 = 1'b0;
    #1;
    chk("R8 same-step response", 17'({co8, s8}), 17'h100);
    // directed corners
    run8(8'hff, 8'h00, 1'b1);
    run8(8'hff, 8'h00, 1'b0);
    run8(8'h55, 8'haa, 1'b1);
    run8(8'h80, 8'h80, 1'b0);
    run8(8'hff, 8'hff, 1'b1);
    run16(16'hffff, 16'h0000, 1'b1);
    run16(16'hffff, 16'hffff, 1'b1);
    run16(16'h00ff, 16'hff00, 1'b0);
    run16(16'h8000, 16'h8000, 1'b0);
    // exhaustive 8-bit sweep
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          run8(8'(a), 8'(b), c[0]);
    // seeded random
    for (int i = 0; i < 400; i++)
      run16(16'($urandom()), 16'($urandom()), 1'($urandom()));
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule